// File: doc/BRIEF.md
# Standby Exit and Oscillator Settling Controller

This block keeps a small microcontroller in a low-power standby state with its oscillator stopped and its system clock gated. While in standby it watches ten wake-up lines (two external interrupt lines and eight wake-up pins) and an active-low reset input. All of these are brought into the controller's clock domain through two-flop synchronizers. A wake line that becomes active during standby is held as pending until a wake is accepted. An interrupt wake is accepted only when the global interrupt mask is clear and the individual enable for that line is set.

When an interrupt wake is accepted, the controller turns on the oscillator and counts a settling interval chosen by a 3-bit code. Only after that interval does it ungate the system clock and emit a one-cycle clock-ready pulse together with an interrupt-entry pulse. It also reports whether execution resumes at high or medium speed. A low level on the reset input takes priority at any time during standby or interrupt settling. On that path the oscillator and the system clock start at once. A reset-entry pulse is issued only after the full settling interval has elapsed and the reset input has returned high. A standby request returns the block from the active state to standby.

Top module: `stby_exit_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `standby_o` is 1 and `osc_en`, `sysclk_en`, `clk_ready_pulse`, `irq_entry_pulse` and `rst_entry_pulse` are 0.
- R2: Wake source index i maps to `irq_pin[i]` for i in 0..1 and to `wake_pin[i-2]` for i in 2..9. A source may wake the block only when `irq_mask_g` is 0 and its enable bit (`irq_en[i]` or `wake_en[i-2]`) is 1. Otherwise the block stays in standby with `osc_en` at 0.
- R3: A source that goes active during standby while its wake is blocked stays pending. It wakes the block once the block (mask or enable) is lifted, even if the pin has since returned low.
- R4: On an accepted interrupt wake, `osc_en` rises first and `sysclk_en` stays 0 for exactly N clock cycles while `osc_en` is 1, then rises.
- R5: N = 2^BASE_LOG2 << k, where k is `settle_sel` for codes 0..3 and k is 4 for any code with bit 2 set. With the default BASE_LOG2 = 13 this gives 8192, 16384, 32768, 65536 and 131072 cycles.
- R6: `irq_entry_pulse` and `clk_ready_pulse` are high for one cycle, in the same cycle `sysclk_en` first becomes 1 on the interrupt path.
- R7: On interrupt exit `speed_medium` equals `med_speed_sel` (1 = medium speed, 0 = high speed). On reset exit `speed_medium` is 0.
- R8: When `rst_n_pin` goes low during standby, `osc_en` and `sysclk_en` become 1 in the same cycle.
- R9: `rst_entry_pulse` is a single-cycle pulse. It appears only after at least N cycles with `osc_en` high and only once `rst_n_pin` is high again; while the pin is held low past settling, no pulse is issued.
- R10: `rst_n_pin` going low during interrupt settling aborts the interrupt wake. No `irq_entry_pulse` follows, the settling count restarts, and the exit ends with `rst_entry_pulse`.
- R11: A one-cycle `standby_req` in the active state returns the block to standby, with `standby_o` at 1 and `osc_en` and `sysclk_en` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high block reset |
| irq_pin | input | N_IRQ | External interrupt lines, asynchronous |
| wake_pin | input | N_WKP | Wake-up pins, asynchronous |
| rst_n_pin | input | 1 | Active-low reset input, asynchronous |
| irq_mask_g | input | 1 | Global interrupt mask (1 blocks interrupt wakes) |
| irq_en | input | N_IRQ | Per-line enables for the interrupt lines |
| wake_en | input | N_WKP | Per-pin enables for the wake-up pins |
| settle_sel | input | 3 | Settling interval code |
| med_speed_sel | input | 1 | Resume at medium speed when 1 |
| standby_req | input | 1 | Return to standby from active |
| osc_en | output | 1 | Oscillator enable |
| sysclk_en | output | 1 | System clock gate enable |
| standby_o | output | 1 | High while in standby |
| clk_ready_pulse | output | 1 | One-cycle pulse at the end of settling |
| irq_entry_pulse | output | 1 | One-cycle interrupt-entry request |
| rst_entry_pulse | output | 1 | One-cycle reset-entry request |
| speed_medium | output | 1 | Resume speed: 1 medium, 0 high |

## Verification
The hardest case to reach is a reset arriving in the middle of an interrupt settling interval. The bench provokes it by starting an interrupt wake with the longest settling code. It waits until `osc_en` has been high for a known number of cycles while `sysclk_en` is still low, then pulls `rst_n_pin` low for a few cycles. A second hard case is a wake that is blocked at the moment the pin is active and accepted later. For that, the bench pulses a pin under the global mask, and in a separate run with the line's enable cleared, confirms that the block stays in standby, and only then lifts the block.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY       = 3'd0,
    ST_SETTLE_IRQ    = 3'd1,
    ST_SETTLE_RST    = 3'd2,
    ST_WAIT_RST_HIGH = 3'd3,
    ST_ACTIVE        = 3'd4
  } stby_state_e;
endpackage

// File: rtl/stby_sync2.sv
module stby_sync2 #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      sync_q <= INIT;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/stby_wake_latch.sv
module stby_wake_latch #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         clear,
  input  logic [N-1:0] src,
  output logic [N-1:0] pend
);
  // one sticky bit per source; clear wins over capture
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hold_q;
    always_ff @(posedge clk) begin
      if (rst || clear) hold_q <= 1'b0;
      else if (capture && src[i]) hold_q <= 1'b1;
    end
    assign pend[i] = hold_q;
  end
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int BASE_LOG2 = 13,
  localparam int CW = BASE_LOG2 + 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       zero
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [2:0]    shift;
  logic [CW-1:0] len_m1;
  logic [CW-1:0] cnt_q;

  always_comb begin
    shift  = sel[2] ? 3'd4 : {1'b0, sel[1:0]};
    len_m1 = (ONE << (BASE_LOG2 + int'(shift))) - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= len_m1;
    else if (run && (cnt_q != '0)) cnt_q <= cnt_q - ONE;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/stby_exit_ctrl.sv
module stby_exit_ctrl
  import stby_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int N_IRQ     = 2,
  parameter int N_WKP     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic [N_WKP-1:0] wake_pin,
  input  logic             rst_n_pin,
  input  logic             irq_mask_g,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_WKP-1:0] wake_en,
  input  logic [2:0]       settle_sel,
  input  logic             med_speed_sel,
  input  logic             standby_req,
  output logic             osc_en,
  output logic             sysclk_en,
  output logic             standby_o,
  output logic             clk_ready_pulse,
  output logic             irq_entry_pulse,
  output logic             rst_entry_pulse,
  output logic             speed_medium
);
  localparam int N_SRC = N_IRQ + N_WKP;

  stby_state_e      state;
  logic [N_SRC-1:0] src_s;
  logic [N_SRC-1:0] pend;
  logic             rst_n_s;
  logic             accept;
  logic             cnt_load;
  logic             cnt_run;
  logic             cnt_zero;
  logic             pend_clr;

  stby_sync2 #(.W(N_SRC), .INIT('0)) u_src_sync (
    .clk(clk), .rst(rst), .din({wake_pin, irq_pin}), .dout(src_s)
  );

  stby_sync2 #(.W(1), .INIT(1'b1)) u_rst_sync (
    .clk(clk), .rst(rst), .din(rst_n_pin), .dout(rst_n_s)
  );

  stby_wake_latch #(.N(N_SRC)) u_pend (
    .clk(clk), .rst(rst),
    .capture(state == ST_STANDBY),
    .clear(pend_clr),
    .src(src_s),
    .pend(pend)
  );

  stby_settle_cnt #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .run(cnt_run),
    .sel(settle_sel), .zero(cnt_zero)
  );

  always_comb begin
    accept   = !irq_mask_g && ((pend & {wake_en, irq_en}) != '0);
    cnt_load = ((state == ST_STANDBY) && (!rst_n_s || accept)) ||
               ((state == ST_SETTLE_IRQ) && !rst_n_s);
    cnt_run  = (state == ST_SETTLE_IRQ) || (state == ST_SETTLE_RST);
    pend_clr = ((state == ST_STANDBY) && cnt_load) ||
               ((state == ST_ACTIVE) && standby_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_STANDBY;
      osc_en          <= 1'b0;
      sysclk_en       <= 1'b0;
      standby_o       <= 1'b1;
      clk_ready_pulse <= 1'b0;
      irq_entry_pulse <= 1'b0;
      rst_entry_pulse <= 1'b0;
      speed_medium    <= 1'b0;
    end else begin
      clk_ready_pulse <= 1'b0;
      irq_entry_pulse <= 1'b0;
      rst_entry_pulse <= 1'b0;
      unique case (state)
        ST_STANDBY: begin
          if (!rst_n_s) begin
            state     <= ST_SETTLE_RST;
            osc_en    <= 1'b1;
            sysclk_en <= 1'b1;
            standby_o <= 1'b0;
          end else if (accept) begin
            state     <= ST_SETTLE_IRQ;
            osc_en    <= 1'b1;
            standby_o <= 1'b0;
          end
        end
        ST_SETTLE_IRQ: begin
          if (!rst_n_s) begin
            state     <= ST_SETTLE_RST;
            sysclk_en <= 1'b1;
          end else if (cnt_zero) begin
            state           <= ST_ACTIVE;
            sysclk_en       <= 1'b1;
            clk_ready_pulse <= 1'b1;
            irq_entry_pulse <= 1'b1;
            speed_medium    <= med_speed_sel;
          end
        end
        ST_SETTLE_RST: begin
          if (cnt_zero) begin
            clk_ready_pulse <= 1'b1;
            if (rst_n_s) begin
              state           <= ST_ACTIVE;
              rst_entry_pulse <= 1'b1;
              speed_medium    <= 1'b0;
            end else begin
              state <= ST_WAIT_RST_HIGH;
            end
          end
        end
        ST_WAIT_RST_HIGH: begin
          if (rst_n_s) begin
            state           <= ST_ACTIVE;
            rst_entry_pulse <= 1'b1;
            speed_medium    <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (standby_req) begin
            state     <= ST_STANDBY;
            osc_en    <= 1'b0;
            sysclk_en <= 1'b0;
            standby_o <= 1'b1;
          end
        end
        default: state <= ST_STANDBY;
      endcase
    end
  end
endmodule

// File: rtl/stby_exit_ctrl_chk.sv
module stby_exit_ctrl_chk
  import stby_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        irq_mask_g,
  input logic        med_speed_sel,
  input logic        osc_en,
  input logic        sysclk_en,
  input logic        standby_o,
  input logic        clk_ready_pulse,
  input logic        irq_entry_pulse,
  input logic        rst_entry_pulse,
  input logic        speed_medium,
  input logic        rst_n_s,
  input stby_state_e state
);
  assert_masked_stays_R2: assert property (@(posedge clk) disable iff (rst)
    (standby_o && irq_mask_g && rst_n_s) |=> standby_o);

  assert_clk_needs_osc_R4: assert property (@(posedge clk) disable iff (rst)
    sysclk_en |-> osc_en);

  assert_entry_with_clock_R6: assert property (@(posedge clk) disable iff (rst)
    irq_entry_pulse |-> (clk_ready_pulse && sysclk_en && !rst_entry_pulse));

  assert_entry_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_entry_pulse |=> !irq_entry_pulse);

  assert_speed_follows_sel_R7: assert property (@(posedge clk) disable iff (rst)
    irq_entry_pulse |-> (speed_medium == $past(med_speed_sel)));

  assert_rst_path_clocked_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE_RST) |-> (sysclk_en && osc_en));

  assert_rst_after_release_R9: assert property (@(posedge clk) disable iff (rst)
    rst_entry_pulse |-> $past(rst_n_s));

  assert_rst_single_R9: assert property (@(posedge clk) disable iff (rst)
    rst_entry_pulse |=> !rst_entry_pulse);

  assert_standby_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> (!osc_en && !sysclk_en));
endmodule

bind stby_exit_ctrl stby_exit_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_mask_g(irq_mask_g), .med_speed_sel(med_speed_sel),
  .osc_en(osc_en), .sysclk_en(sysclk_en), .standby_o(standby_o),
  .clk_ready_pulse(clk_ready_pulse), .irq_entry_pulse(irq_entry_pulse),
  .rst_entry_pulse(rst_entry_pulse), .speed_medium(speed_medium),
  .rst_n_s(rst_n_s), .state(state)
);

// File: tb/sim_stby_exit_ctrl.sv
`timescale 1ns/1ps
module sim_stby_exit_ctrl;
  localparam int BL = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irq_pin = '0;
  logic [7:0] wake_pin = '0;
  logic       rst_n_pin = 1'b1;
  logic       irq_mask_g = 1'b0;
  logic [1:0] irq_en = '0;
  logic [7:0] wake_en = '0;
  logic [2:0] settle_sel = '0;
  logic       med_speed_sel = 1'b0;
  logic       standby_req = 1'b0;
  logic osc_en, sysclk_en, standby_o, clk_ready_pulse;
  logic irq_entry_pulse, rst_entry_pulse, speed_medium;

  always #5 clk = ~clk;

  stby_exit_ctrl #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .wake_pin(wake_pin),
    .rst_n_pin(rst_n_pin), .irq_mask_g(irq_mask_g), .irq_en(irq_en),
    .wake_en(wake_en), .settle_sel(settle_sel), .med_speed_sel(med_speed_sel),
    .standby_req(standby_req), .osc_en(osc_en), .sysclk_en(sysclk_en),
    .standby_o(standby_o), .clk_ready_pulse(clk_ready_pulse),
    .irq_entry_pulse(irq_entry_pulse), .rst_entry_pulse(rst_entry_pulse),
    .speed_medium(speed_medium)
  );

  typedef struct {
    bit is_rst;
    bit med;
    int n;
    bit abort;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int rst_seen = 0;
  int osc_cnt = 0;
  int gap_cnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int settle_len(input int sel);
    return (1 << BL) << ((sel >= 4) ? 4 : sel);
  endfunction

  // monitor: measure settling, pop expected exits and compare
  always @(negedge clk) begin
    if (rst || !osc_en) begin
      osc_cnt = 0;
      gap_cnt = 0;
    end else begin
      osc_cnt++;
      if (!sysclk_en) gap_cnt++;
    end
    if (!rst && (irq_entry_pulse || rst_entry_pulse)) begin
      if (irq_entry_pulse) irq_seen++;
      if (rst_entry_pulse) rst_seen++;
      if (q.size() == 0) begin
        chk(1'b0, "R6", "unexpected exit pulse", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rst_entry_pulse == e.is_rst, e.abort ? "R10" : "R9",
            "exit kind (1=reset)", int'(rst_entry_pulse), int'(e.is_rst));
        chk(speed_medium == e.med, "R7", "speed_medium at exit",
            int'(speed_medium), int'(e.med));
        if (!e.is_rst) begin
          chk(gap_cnt == e.n, "R4", "cycles osc on, clock gated", gap_cnt, e.n);
          chk(clk_ready_pulse && sysclk_en, "R6", "ready pulse with clock",
              int'(clk_ready_pulse && sysclk_en), 1);
        end else begin
          chk(osc_cnt >= e.n, "R9", "reset exit before settling", osc_cnt, e.n);
          if (!e.abort)
            chk(gap_cnt == 0, "R8", "gated cycles on reset path", gap_cnt, 0);
        end
      end
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_sysclk(input string req);
    int k = 0;
    while (!sysclk_en && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk(sysclk_en, req, "system clock never enabled", int'(sysclk_en), 1);
  endtask

  task automatic pulse_src(input int src);
    @(negedge clk);
    if (src < 2) irq_pin[src] = 1'b1;
    else wake_pin[src-2] = 1'b1;
    wait_cycles(3);
    irq_pin = '0;
    wake_pin = '0;
  endtask

  task automatic go_standby();
    @(negedge clk);
    standby_req = 1'b1;
    @(negedge clk);
    standby_req = 1'b0;
    chk(standby_o && !osc_en && !sysclk_en, "R11", "standby after request",
        int'({standby_o, osc_en, sysclk_en}), 4);
    wait_cycles(3);
  endtask

  task automatic irq_wake(input int src, input int sel, input bit med);
    settle_sel = 3'(sel);
    med_speed_sel = med;
    q.push_back('{is_rst: 1'b0, med: med, n: settle_len(sel), abort: 1'b0});
    pulse_src(src);
    wait_sysclk("R5");
    go_standby();
  endtask

  initial begin
    int prev;
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    chk(standby_o && !osc_en && !sysclk_en && !clk_ready_pulse &&
        !irq_entry_pulse && !rst_entry_pulse, "R1", "reset state",
        int'({standby_o, osc_en, sysclk_en, clk_ready_pulse,
              irq_entry_pulse, rst_entry_pulse}), 32);

    // every settling code, rotating sources and speed
    irq_en = 2'b11;
    wake_en = 8'hFF;
    for (int s = 0; s < 8; s++) irq_wake(s % 10, s, s[0]);
    irq_wake(9, 1, 1'b1);

    // R2 / R3: blocked by the global mask, then released
    irq_mask_g = 1'b1;
    pulse_src(5);
    wait_cycles(30);
    chk(standby_o && !osc_en, "R2", "masked wake left standby",
        int'({standby_o, osc_en}), 2);
    settle_sel = 3'd0;
    med_speed_sel = 1'b0;
    q.push_back('{is_rst: 1'b0, med: 1'b0, n: settle_len(0), abort: 1'b0});
    irq_mask_g = 1'b0;
    wait_sysclk("R3");
    go_standby();

    // R2 / R3: blocked by the individual enable, then enabled
    wake_en = 8'h00;
    irq_en = 2'b01;
    pulse_src(7);
    pulse_src(1);
    wait_cycles(30);
    chk(standby_o && !osc_en, "R2", "disabled source left standby",
        int'({standby_o, osc_en}), 2);
    q.push_back('{is_rst: 1'b0, med: 1'b1, n: settle_len(2), abort: 1'b0});
    settle_sel = 3'd2;
    med_speed_sel = 1'b1;
    wake_en = 8'h20;
    wait_sysclk("R3");
    go_standby();
    wake_en = 8'hFF;
    irq_en = 2'b11;

    // R8 / R9: reset held low well past settling
    settle_sel = 3'd1;
    q.push_back('{is_rst: 1'b1, med: 1'b0, n: settle_len(1), abort: 1'b0});
    prev = rst_seen;
    @(negedge clk);
    rst_n_pin = 1'b0;
    wait_cycles(60);
    chk(osc_en && sysclk_en, "R8", "clock running while reset low",
        int'({osc_en, sysclk_en}), 3);
    chk(rst_seen == prev, "R9", "reset entry while pin low", rst_seen, prev);
    rst_n_pin = 1'b1;
    wait_cycles(5);
    chk(rst_seen == prev + 1, "R9", "reset entry after release", rst_seen, prev + 1);
    go_standby();

    // R9: short reset pulse, exit waits for full settling
    settle_sel = 3'd2;
    q.push_back('{is_rst: 1'b1, med: 1'b0, n: settle_len(2), abort: 1'b0});
    prev = rst_seen;
    @(negedge clk);
    rst_n_pin = 1'b0;
    wait_cycles(4);
    rst_n_pin = 1'b1;
    wait_cycles(settle_len(2) + 8);
    chk(rst_seen == prev + 1, "R9", "short reset exit count", rst_seen, prev + 1);
    go_standby();

    // R10: reset during interrupt settling
    settle_sel = 3'd4;
    med_speed_sel = 1'b1;
    q.push_back('{is_rst: 1'b1, med: 1'b0, n: settle_len(4), abort: 1'b1});
    prev = irq_seen;
    pulse_src(0);
    wait_cycles(20);
    chk(osc_en && !sysclk_en, "R4", "still settling before abort",
        int'({osc_en, sysclk_en}), 2);
    rst_n_pin = 1'b0;
    wait_cycles(5);
    rst_n_pin = 1'b1;
    wait_cycles(settle_len(4) + 10);
    chk(irq_seen == prev, "R10", "interrupt entry after abort", irq_seen, prev);
    chk(speed_medium == 1'b0, "R7", "speed after reset exit", int'(speed_medium), 0);
    go_standby();

    chk(q.size() == 0, "R6", "expected exits left over", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule